// File: doc/BRIEF.md
# Normalizing Barrel Shifter

This block is a registered shifter for 16-bit fixed-point data with a 32-bit result field. Before any shift, the input word is placed in either the upper or the lower half of the 32-bit field. In the lower half it is zero-extended for logical work and sign-extended for arithmetic work. The shift direction and distance come from a signed 6-bit amount.

Besides plain logical and arithmetic shifts, the block supports numeric-format work:
- It counts the redundant sign bits of a word, which gives its exponent.
- It normalizes a word by removing those bits in a single operation.
- It denormalizes a word by shifting it right by a supplied exponent.
- It folds derived exponents into a running block exponent, which is used for block floating-point arrays.

A caller presents an operation with `valid_i`. The results appear on the registered outputs at the next clock edge and hold until another operation updates them.

Top module: `norm_shifter`

## Requirements
- R1: After reset, `result_o` is 0, `exp_o` is 0 and `blk_exp_o` is 15.
- R2: Opcode 0 is a logical shift. The field is `{data_i,16'h0}` when `hi_sel_i`=1 and `{16'h0,data_i}` when `hi_sel_i`=0. The amount `shamt_i` is two's complement: a positive value shifts left and a negative value shifts right by its magnitude, with zero fill in both directions. The result appears at the clock edge that samples `valid_i`=1.
- R3: Opcode 1 is an arithmetic shift. With `hi_sel_i`=0 the field is `data_i` sign-extended to 32 bits, and with `hi_sel_i`=1 it is the same as in R2. A right shift fills with bit 31 of the field, and a left shift fills with zeros.
- R4: The amount range is -32 to +31. A shift of -32 gives 0 for a logical shift and all copies of the field's sign bit for an arithmetic shift. A shift of +31 keeps only field bit 0, which ends up in bit 31.
- R5: Opcode 4 sets `exp_o` to the redundant sign count. This is the number of consecutive bits below bit 15 that equal bit 15, so it is 15 for 0x0000 and 0xFFFF. `result_o` is unchanged by this opcode.
- R6: Opcode 2 normalizes. `result_o` is the arithmetic field shifted left by the redundant sign count of `data_i`, and `exp_o` takes that count.
- R7: Opcode 3 denormalizes. `result_o` is the arithmetic field shifted right by `shamt_i`, or left by its magnitude when `shamt_i` is negative. `exp_o` is unchanged.
- R8: Opcode 5 sets `exp_o` to the redundant sign count and sets `blk_exp_o` to the minimum of its old value and that count. `result_o` is unchanged.
- R9: `blk_clr_i`=1 sets `blk_exp_o` to 15 at the next edge. It takes priority over an opcode 5 in the same cycle, although `exp_o` still updates in that case.
- R10: When `valid_i`=0, or when the opcode is 6 or 7, `result_o`, `exp_o` and `blk_exp_o` keep their values (except for a clear under R9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Opcode (0 lsh, 1 ash, 2 norm, 3 denorm, 4 exp, 5 block exp) |
| data_i | input | 16 | Input word |
| shamt_i | input | 6 | Signed shift amount or exponent |
| hi_sel_i | input | 1 | Place word in upper half when 1 |
| blk_clr_i | input | 1 | Reset block exponent to 15 |
| result_o | output | 32 | Shifted result |
| exp_o | output | 4 | Derived exponent |
| blk_exp_o | output | 4 | Running block exponent |

## Verification
Each result, exponent and block exponent is due at the first rising edge that samples `valid_i`=1 or `blk_clr_i`=1. Nothing in the block adds further latency. The bench drives every stimulus on a falling edge and drops the strobe at the following falling edge. It then reads all three outputs there, half a cycle after the edge that updated them and before any later stimulus. Checks that an output holds read it on the same falling edge after the strobe. The bench compares each reading with a bit-by-bit model written from the requirements.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [2:0] {
    OP_LSH  = 3'd0,
    OP_ASH  = 3'd1,
    OP_NORM = 3'd2,
    OP_DNRM = 3'd3,
    OP_EXP  = 3'd4,
    OP_BEXP = 3'd5
  } nbs_op_e;
endpackage

// File: rtl/nbs_sign_count.sv
module nbs_sign_count #(
  parameter int DW = 16,
  localparam int CW = $clog2(DW)
) (
  input  logic [DW-1:0] d_i,
  output logic [CW-1:0] cnt_o
);
  logic run;
  always_comb begin
    cnt_o = '0;
    run   = 1'b1;
    for (int i = DW-2; i >= 0; i--) begin
      if (run && (d_i[i] == d_i[DW-1])) cnt_o = cnt_o + CW'(1);
      else run = 1'b0;
    end
  end
endmodule

// File: rtl/nbs_shift_core.sv
module nbs_shift_core #(
  parameter int DW = 16,
  localparam int RW = 2*DW,
  localparam int SW = $clog2(RW) + 1
) (
  input  logic [DW-1:0] data_i,
  input  logic          hi_sel_i,
  input  logic          arith_i,
  input  logic          left_i,
  input  logic [SW-1:0] mag_i,
  output logic [RW-1:0] res_o
);
  logic [RW-1:0]   field;
  logic [2*RW-1:0] wide;

  always_comb begin
    if (hi_sel_i) field = {data_i, {DW{1'b0}}};
    else          field = {{DW{arith_i & data_i[DW-1]}}, data_i};
    // double-width so a full-width shift clears or sign-fills cleanly
    if (left_i) wide = {{RW{1'b0}}, field} << mag_i;
    else        wide = {{RW{arith_i & field[RW-1]}}, field} >> mag_i;
    res_o = wide[RW-1:0];
  end
endmodule

// File: rtl/nbs_blk_exp.sv
module nbs_blk_exp #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          upd_i,
  input  logic [CW-1:0] exp_i,
  output logic [CW-1:0] blk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   blk_o <= '1;
    else if (clr_i)                blk_o <= '1;
    else if (upd_i && exp_i < blk_o) blk_o <= exp_i;
  end

  // R8
  blk_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> blk_o <= $past(blk_o));
  // R9
  blk_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> blk_o == '1);
endmodule

// File: rtl/norm_shifter.sv
module norm_shifter
  import nbs_pkg::*;
#(
  parameter int DW = 16,
  localparam int RW = 2*DW,
  localparam int SW = $clog2(RW) + 1,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] data_i,
  input  logic [SW-1:0] shamt_i,
  input  logic          hi_sel_i,
  input  logic          blk_clr_i,
  output logic [RW-1:0] result_o,
  output logic [CW-1:0] exp_o,
  output logic [CW-1:0] blk_exp_o
);
  logic [CW-1:0] cnt;
  logic [RW-1:0] shf;
  logic [SW-1:0] amt_mag;
  logic          amt_neg, arith, left;
  logic [SW-1:0] mag;
  logic          res_we, exp_we, blk_upd;

  nbs_sign_count #(.DW(DW)) u_cnt (.d_i(data_i), .cnt_o(cnt));

  assign amt_neg = shamt_i[SW-1];
  assign amt_mag = amt_neg ? (~shamt_i + 1'b1) : shamt_i;

  always_comb begin
    arith   = 1'b1;
    left    = !amt_neg;
    mag     = amt_mag;
    res_we  = 1'b0;
    exp_we  = 1'b0;
    blk_upd = 1'b0;
    unique case (op_i)
      OP_LSH:  begin arith = 1'b0; res_we = 1'b1; end
      OP_ASH:  res_we = 1'b1;
      OP_NORM: begin left = 1'b1; mag = SW'(cnt); res_we = 1'b1; exp_we = 1'b1; end
      OP_DNRM: begin left = amt_neg; res_we = 1'b1; end
      OP_EXP:  exp_we = 1'b1;
      OP_BEXP: begin exp_we = 1'b1; blk_upd = 1'b1; end
      default: ;
    endcase
  end

  nbs_shift_core #(.DW(DW)) u_core (
    .data_i(data_i), .hi_sel_i(hi_sel_i), .arith_i(arith),
    .left_i(left), .mag_i(mag), .res_o(shf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      exp_o    <= '0;
    end else if (valid_i) begin
      if (res_we) result_o <= shf;
      if (exp_we) exp_o    <= cnt;
    end
  end

  nbs_blk_exp #(.CW(CW)) u_blk (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(blk_clr_i),
    .upd_i(valid_i && blk_upd), .exp_i(cnt), .blk_o(blk_exp_o)
  );

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(exp_o));
  // R5
  exp_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_EXP && (data_i == '0 || data_i == '1)) |=> exp_o == CW'(DW-1));
  // R6
  norm_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_NORM && hi_sel_i && data_i != '0 && data_i != '1)
      |=> result_o[RW-1] != result_o[RW-2]);
  // R8
  blk_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_BEXP && !blk_clr_i) |=> blk_exp_o <= exp_o);
endmodule

// File: tb/tb_norm_shifter.sv
`timescale 1ns/1ps
module tb_norm_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] data = '0;
  logic [5:0]  shamt = '0;
  logic        hi_sel = 1'b0;
  logic        blk_clr = 1'b0;
  logic [31:0] result;
  logic [3:0]  exp_v, blk_v;

  int n_tests = 0, n_fail = 0;
  logic [31:0] m_res = '0;
  int          m_exp = 0, m_blk = 15;

  always #2.5 clk = ~clk;

  norm_shifter dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .data_i(data),
    .shamt_i(shamt), .hi_sel_i(hi_sel), .blk_clr_i(blk_clr),
    .result_o(result), .exp_o(exp_v), .blk_exp_o(blk_v)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int rsc(logic [15:0] d);
    int n = 0;
    for (int i = 14; i >= 0; i--) begin
      if (d[i] != d[15]) break;
      n++;
    end
    return n;
  endfunction

  function automatic logic [31:0] mshift(logic [15:0] d, bit hi, bit ar, bit lft, int m);
    logic [31:0] f, r;
    bit fill;
    f = hi ? {d, 16'h0} : (ar ? {{16{d[15]}}, d} : {16'h0, d});
    fill = ar & f[31];
    for (int i = 0; i < 32; i++) begin
      if (lft) r[i] = (i >= m) ? f[i-m] : 1'b0;
      else     r[i] = (i + m < 32) ? f[i+m] : fill;
    end
    return r;
  endfunction

  task automatic run_op(string tag, int o, logic [15:0] d, int sh, bit hi);
    int mag;
    mag = (sh < 0) ? -sh : sh;
    @(negedge clk);
    op = 3'(o); data = d; shamt = 6'(sh); hi_sel = hi; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    case (o)
      0: m_res = mshift(d, hi, 1'b0, sh >= 0, mag);
      1: m_res = mshift(d, hi, 1'b1, sh >= 0, mag);
      2: begin m_res = mshift(d, hi, 1'b1, 1'b1, rsc(d)); m_exp = rsc(d); end
      3: m_res = mshift(d, hi, 1'b1, sh < 0, mag);
      4: m_exp = rsc(d);
      5: begin m_exp = rsc(d); if (rsc(d) < m_blk) m_blk = rsc(d); end
      default: ;
    endcase
    check({tag, " result"}, result, m_res);
    check({tag, " exp"}, 32'(exp_v), 32'(m_exp));
    check({tag, " blk"}, 32'(blk_v), 32'(m_blk));
  endtask

  task automatic t_reset;
    check("R1 result", result, 32'h0);
    check("R1 exp", 32'(exp_v), 32'h0);
    check("R1 blk", 32'(blk_v), 32'd15);
  endtask

  task automatic t_lsh;
    run_op("R2 lo left", 0, 16'h8421, 4, 0);
    run_op("R2 hi left", 0, 16'h8421, 3, 1);
    run_op("R2 hi right", 0, 16'hF00F, -5, 1);
    run_op("R2 lo right", 0, 16'h8001, -1, 0);
  endtask

  task automatic t_ash;
    run_op("R3 lo sext right", 1, 16'h8001, -3, 0);
    run_op("R3 hi right", 1, 16'hA5A5, -8, 1);
    run_op("R3 lo left", 1, 16'hC003, 2, 0);
    run_op("R3 pos right", 1, 16'h7FFF, -4, 1);
  endtask

  task automatic t_bounds;
    run_op("R4 lsh -32", 0, 16'hFFFF, -32, 1);
    check("R4 lsh -32 zero", result, 32'h0);
    run_op("R4 ash -32", 1, 16'h8000, -32, 1);
    check("R4 ash -32 ones", result, 32'hFFFF_FFFF);
    run_op("R4 lsh +31", 0, 16'h0001, 31, 0);
    check("R4 lsh +31 msb", result, 32'h8000_0000);
  endtask

  task automatic t_exp;
    logic [31:0] keep;
    keep = result;
    run_op("R5 zero", 4, 16'h0000, 0, 0);
    check("R5 zero=15", 32'(exp_v), 32'd15);
    run_op("R5 ones", 4, 16'hFFFF, 0, 0);
    check("R5 ones=15", 32'(exp_v), 32'd15);
    run_op("R5 0x0001", 4, 16'h0001, 0, 0);
    run_op("R5 0xC000", 4, 16'hC000, 0, 0);
    run_op("R5 0x4000", 4, 16'h4000, 0, 0);
    check("R5 result held", result, keep);
  endtask

  task automatic t_norm;
    run_op("R6 hi", 2, 16'h0123, 0, 1);
    run_op("R6 lo neg", 2, 16'hFF80, 0, 0);
    run_op("R6 already", 2, 16'h4000, 0, 1);
  endtask

  task automatic t_denorm;
    run_op("R7 right", 3, 16'h9000, 5, 1);
    run_op("R7 neg left", 3, 16'h0101, -3, 0);
    run_op("R7 lo right", 3, 16'h8000, 2, 0);
  endtask

  task automatic t_bexp;
    run_op("R8 first", 5, 16'h00FF, 0, 0);
    run_op("R8 larger kept", 5, 16'h0001, 0, 0);
    run_op("R8 smaller", 5, 16'hF000, 0, 0);
  endtask

  task automatic t_clear;
    @(negedge clk);
    blk_clr = 1'b1; valid = 1'b1; op = 3'd5; data = 16'h2000;
    @(negedge clk);
    blk_clr = 1'b0; valid = 1'b0;
    m_blk = 15; m_exp = rsc(16'h2000);
    check("R9 clr wins blk", 32'(blk_v), 32'd15);
    check("R9 exp still updates", 32'(exp_v), 32'(m_exp));
    run_op("R9 after clr", 5, 16'h0700, 0, 0);
  endtask

  task automatic t_hold;
    logic [31:0] r0;
    logic [3:0]  e0, b0;
    r0 = result; e0 = exp_v; b0 = blk_v;
    @(negedge clk);
    valid = 1'b0; op = 3'd0; data = 16'h1234; shamt = 6'd4;
    @(negedge clk);
    check("R10 no valid result", result, r0);
    run_op("R10 op6", 6, 16'h0000, 3, 1);
    run_op("R10 op7", 7, 16'hFFFF, -2, 0);
    check("R10 op6/7 result", result, r0);
    check("R10 op6/7 exp", 32'(exp_v), 32'(e0));
    check("R10 op6/7 blk", 32'(blk_v), 32'(b0));
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lsh();
    t_ash();
    t_bounds();
    t_exp();
    t_norm();
    t_denorm();
    t_bexp();
    t_clear();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule